// File: doc/BRIEF.md
# Coincidence-Sampled Early/Late Phase Detector

This block sits in the fast oscillator clock domain of a digital phase-locked loop. It decides whether the oscillator leads or lags a slower reference clock. The two clocks share an edge only once per long common period. With a 155.52 MHz oscillator and a 10 MHz reference, 125 reference cycles fill the same time as 1944 oscillator cycles, so they line up every 12.5 µs (80 kHz). A modulo counter on the fast clock picks out that one cycle. The compare output of the counter is registered on the undivided fast clock, so divider delay and jitter do not reach the sampling point. The reference level is then captured on the following edge.

Each capture gives one bit of information: late when the reference is already high, early when it is still low. The bit passes through a configurable number of extra flop stages that give a metastable capture time to settle. It is then presented with a one-cycle valid strobe. A signed saturating accumulator sums the decisions as +1 or −1 for a downstream digital loop filter. The accumulator can be cleared synchronously.

Top module: `coinc_bbpd`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the coincidence counter is at state 0, `decValid` is 0, `decLate` is 0 and `errAcc` is 0.
- R2: `decValid` is high for exactly one cycle and never on two consecutive cycles. Pulses come only on cycles that follow edge number k after reset release, where k mod DIV_RATIO equals 2+SYNC_STAGES (default DIV_RATIO 1944, SYNC_STAGES 1, so edges 3, 1947, ...).
- R3: The decision uses only the level of `refIn` at edge number k with k mod DIV_RATIO equal to 2. The value of `refIn` at any other edge does not affect any output.
- R4: `decLate` is 1 when the captured reference level was 1 (late, +1) and 0 when it was 0 (early, −1). `decLate` keeps the last decision until the next strobe.
- R5: `detectEn` matters only at edge number k with k mod DIV_RATIO equal to 1. If it is low there, that comparison produces no `decValid` pulse and does not change `errAcc`. Its value at any other edge has no effect.
- R6: On the cycle `decValid` rises, `errAcc` is one step higher for a late decision or one step lower for an early one. On every other cycle it holds, unless a clear was applied on the previous edge.
- R7: `errAcc` is a two's-complement value of ACC_W bits. It saturates at 2^(ACC_W−1)−1 and at −2^(ACC_W−1) and does not wrap.
- R8: `accClear` high at an edge makes `errAcc` 0 after that edge. This holds even when a decision is accumulated at the same edge. That decision is dropped from the sum, but its `decValid` and `decLate` still appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Active-high synchronous reset |
| detectEn | input | 1 | Enables comparisons |
| refIn | input | 1 | Squared reference clock level |
| accClear | input | 1 | Synchronous clear of the accumulator |
| decValid | output | 1 | One-cycle strobe for a new decision |
| decLate | output | 1 | Last decision: 1 late, 0 early |
| errAcc | output | ACC_W | Signed saturating sum of decisions |

## Verification
A decision is accumulated on the same edge that a clear can arrive. The bench drives `accClear` on exactly the edge that raises `decValid`, and also one cycle before it. It expects the strobe and the bit to appear unchanged while the sum reads zero. The enable and reference inputs are randomised on every cycle other than their one relevant edge, so a design that listens at the wrong edge diverges from the bench's model of the next decision and the next sum. Saturation is reached in both directions with a narrow accumulator width.

// File: rtl/coinc_bbpd_pkg.sv
package coinc_bbpd_pkg;

  // Strobes passed from control to datapath each fast-clock cycle
  typedef struct packed {
    logic sampleStb;  // retimed coincidence marker, gated by enable
    logic accClr;     // synchronous clear of the error sum
  } pdStrobes_t;

endpackage

// File: rtl/coinc_bbpd_ctrl.sv
module coinc_bbpd_ctrl
  import coinc_bbpd_pkg::*;
#(
  parameter int DIV_RATIO = 1944
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       detectEn,
  input  logic       accClear,
  output pdStrobes_t strobes
);

  localparam int CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cntQ;
  logic             coincRaw;
  logic             markQ;

  // Modulo counter: state 0 is the only state aligned with a reference edge
  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
    end else if (cntQ == CNT_LAST) begin
      cntQ <= '0;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign coincRaw = (cntQ == '0);

  // Retime the decoded marker on the undivided clock so the sampling
  // point carries no decode delay or divider jitter
  always_ff @(posedge clk) begin
    if (rst) begin
      markQ <= 1'b0;
    end else begin
      markQ <= coincRaw & detectEn;
    end
  end

  assign strobes.sampleStb = markQ;
  assign strobes.accClr    = accClear;

endmodule

// File: rtl/coinc_bbpd_dp.sv
module coinc_bbpd_dp
  import coinc_bbpd_pkg::*;
#(
  parameter int SYNC_STAGES = 1,
  parameter int ACC_W       = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    refIn,
  input  pdStrobes_t              strobes,
  output logic                    decValid,
  output logic                    decLate,
  output logic signed [ACC_W-1:0] errAcc
);

  localparam int PIPE_L = 1 + SYNC_STAGES;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] ACC_ONE = ACC_W'(1);

  logic [PIPE_L-1:0] vldPipe, bitPipe;
  logic [PIPE_L-1:0] vldIn, bitIn;
  logic signed [ACC_W-1:0] accQ, accNext;

  // Stage 0 is the sampling flop; later stages settle metastability
  assign vldIn[0] = strobes.sampleStb;
  assign bitIn[0] = refIn;

  generate
    for (genvar g = 1; g < PIPE_L; g++) begin : g_syncFeed
      assign vldIn[g] = vldPipe[g-1];
      assign bitIn[g] = bitPipe[g-1];
    end
  endgenerate

  generate
    for (genvar s = 0; s < PIPE_L; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          vldPipe[s] <= 1'b0;
          bitPipe[s] <= 1'b0;
        end else begin
          vldPipe[s] <= vldIn[s];
          if (vldIn[s]) begin
            bitPipe[s] <= bitIn[s];
          end
        end
      end
    end
  endgenerate

  // Accumulate on the edge that loads the final stage, so the sum and
  // the strobe change together; a clear on the same edge wins
  always_comb begin
    accNext = accQ;
    if (strobes.accClr) begin
      accNext = '0;
    end else if (vldIn[PIPE_L-1]) begin
      if (bitIn[PIPE_L-1]) begin
        if (accQ != ACC_MAX) accNext = accQ + ACC_ONE;
      end else begin
        if (accQ != ACC_MIN) accNext = accQ - ACC_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= '0;
    end else begin
      accQ <= accNext;
    end
  end

  assign decValid = vldPipe[PIPE_L-1];
  assign decLate  = bitPipe[PIPE_L-1];
  assign errAcc   = accQ;

endmodule

// File: rtl/coinc_bbpd.sv
module coinc_bbpd
  import coinc_bbpd_pkg::*;
#(
  parameter int DIV_RATIO   = 1944,
  parameter int SYNC_STAGES = 1,
  parameter int ACC_W       = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    detectEn,
  input  logic                    refIn,
  input  logic                    accClear,
  output logic                    decValid,
  output logic                    decLate,
  output logic signed [ACC_W-1:0] errAcc
);

  pdStrobes_t strobes;

  coinc_bbpd_ctrl #(
    .DIV_RATIO(DIV_RATIO)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .detectEn(detectEn),
    .accClear(accClear),
    .strobes (strobes)
  );

  coinc_bbpd_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .ACC_W      (ACC_W)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .refIn   (refIn),
    .strobes (strobes),
    .decValid(decValid),
    .decLate (decLate),
    .errAcc  (errAcc)
  );

endmodule

// File: rtl/coinc_bbpd_chk.sv
module coinc_bbpd_chk #(
  parameter int DIV_RATIO   = 1944,
  parameter int SYNC_STAGES = 1,
  parameter int ACC_W       = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    accClear,
  input logic                    decValid,
  input logic                    decLate,
  input logic signed [ACC_W-1:0] errAcc
);

  localparam int PH_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [PH_W-1:0] PH_PULSE = PH_W'((2 + SYNC_STAGES) % DIV_RATIO);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(DIV_RATIO - 1);

  // Edges since reset release, modulo the coincidence period
  logic [PH_W-1:0] phaseQ;
  always_ff @(posedge clk) begin
    if (rst) phaseQ <= '0;
    else if (phaseQ == PH_LAST) phaseQ <= '0;
    else phaseQ <= phaseQ + 1'b1;
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    decValid |=> !decValid);

  a_r2_pulse_phase: assert property (@(posedge clk) disable iff (rst)
    decValid |-> (phaseQ == PH_PULSE));

  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!decValid && !$past(accClear)) |-> $stable(errAcc));

  a_r6_unit_step: assert property (@(posedge clk) disable iff (rst)
    (decValid && !$past(accClear)) |->
      ((int'(errAcc) - int'($past(errAcc)) <= 1) &&
       (int'(errAcc) - int'($past(errAcc)) >= -1)));

  a_r4_late_up: assert property (@(posedge clk) disable iff (rst)
    (decValid && !$past(accClear) && decLate) |-> (int'(errAcc) >= int'($past(errAcc))));

  a_r4_early_down: assert property (@(posedge clk) disable iff (rst)
    (decValid && !$past(accClear) && !decLate) |-> (int'(errAcc) <= int'($past(errAcc))));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    $past(accClear) |-> (errAcc == '0));

endmodule

bind coinc_bbpd coinc_bbpd_chk #(
  .DIV_RATIO  (DIV_RATIO),
  .SYNC_STAGES(SYNC_STAGES),
  .ACC_W      (ACC_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .accClear(accClear),
  .decValid(decValid),
  .decLate (decLate),
  .errAcc  (errAcc)
);

// File: tb/coinc_bbpd_tb_top.sv
`timescale 1ns/1ps
module coinc_bbpd_tb_top;

  localparam int DIV  = 1944;
  localparam int SYNC = 1;
  localparam int ACCW = 4;   // narrow sum so saturation is reachable
  localparam int AMAX = (1 << (ACCW-1)) - 1;
  localparam int AMIN = -(1 << (ACCW-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic detectEn = 1'b0;
  logic refIn = 1'b0;
  logic accClear = 1'b0;
  logic decValid, decLate;
  logic signed [ACCW-1:0] errAcc;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  int  edgeK;
  bit  enCap, refCap, expValid, expLate;
  int  expAcc;

  always #2 clk = ~clk;

  coinc_bbpd #(.DIV_RATIO(DIV), .SYNC_STAGES(SYNC), .ACC_W(ACCW)) dut_i (
    .clk(clk), .rst(rst), .detectEn(detectEn), .refIn(refIn),
    .accClear(accClear), .decValid(decValid), .decLate(decLate), .errAcc(errAcc)
  );

  function automatic int satStep(int a, bit up);
    if (up) return (a >= AMAX) ? AMAX : a + 1;
    return (a <= AMIN) ? AMIN : a - 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, edgeK, act, exp);
    end
  endtask

  task automatic compare(string accTag);
    check(decValid == expValid, "R2 R5 valid", int'(decValid), int'(expValid));
    check(decLate == expLate, "R3 R4 decision", int'(decLate), int'(expLate));
    check(int'(errAcc) == expAcc, accTag, int'(errAcc), expAcc);
  endtask

  // Drive inputs for the next edge, predict, then sample at the negedge
  task automatic step(bit en, bit rf, bit clr, string accTag);
    int ph;
    detectEn = en; refIn = rf; accClear = clr;
    ph = edgeK % DIV;
    if (ph == 1) enCap = en;
    if (ph == 2) refCap = rf;
    expValid = (ph == 2 + SYNC) && enCap;
    if (expValid) expLate = refCap;
    if (clr) expAcc = 0;
    else if (expValid) expAcc = satStep(expAcc, refCap);
    @(negedge clk);
    compare(accTag);
    edgeK++;
  endtask

  task automatic doReset(int n);
    rst = 1'b1; detectEn = 1'b0; refIn = 1'b0; accClear = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(decValid == 1'b0, "R1 valid in reset", int'(decValid), 0);
      check(decLate == 1'b0, "R1 decision in reset", int'(decLate), 0);
      check(errAcc == '0, "R1 sum in reset", int'(errAcc), 0);
    end
    rst = 1'b0;
    edgeK = 1; enCap = 1'b0; refCap = 1'b0;
    expValid = 1'b0; expLate = 1'b0; expAcc = 0;
  endtask

  // enMode/refMode: 0 force low, 1 force high, 2 random at the relevant edge
  // clrPh: phase at which a clear is applied, -1 none, -2 random sparse
  task automatic runPeriod(int enMode, int refMode, int clrPh, string accTag);
    for (int c = 0; c < DIV; c++) begin
      int  ph;
      bit  en, rf, clr;
      ph = edgeK % DIV;
      en  = 1'($urandom_range(0, 1));
      rf  = 1'($urandom_range(0, 1));
      clr = 1'b0;
      if (ph == 1) en = (enMode == 2) ? 1'($urandom_range(0, 1)) : 1'(enMode);
      if (ph == 2) rf = (refMode == 2) ? 1'($urandom_range(0, 1)) : 1'(refMode);
      if (clrPh >= 0) clr = (ph == clrPh);
      else if (clrPh == -2) clr = ($urandom_range(0, 999) == 0);
      step(en, rf, clr, accTag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240917));
    edgeK = 1;
    doReset(4);
    // R2 first pulse on edge 3, R6 climb, R7 positive saturation
    for (int p = 0; p < 10; p++) runPeriod(1, 1, -1, "R7 upper saturation");
    // R5 enable low at its edge: no pulse, sum holds
    for (int p = 0; p < 2; p++) runPeriod(0, 1, -1, "R5 disabled sum");
    // R6 descent and R7 negative saturation
    for (int p = 0; p < 18; p++) runPeriod(1, 0, -1, "R7 lower saturation");
    // R8 clear on the strobe edge, then one cycle earlier
    runPeriod(1, 1, 2 + SYNC, "R8 clear collides");
    runPeriod(1, 0, 1 + SYNC, "R8 clear before strobe");
    runPeriod(1, 1, 500, "R8 clear mid period");
    // Mixed random comparisons with sparse clears (R3 R4 R5 R6)
    for (int p = 0; p < 16; p++) runPeriod(2, 2, -2, "R6 random sum");
    // R1 reset mid period restarts the counter
    for (int c = 0; c < 700; c++) step(1'b1, 1'($urandom_range(0, 1)), 1'b0, "R6 random sum");
    doReset(3);
    for (int p = 0; p < 3; p++) runPeriod(2, 2, -1, "R1 restart sum");
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(4.0 * 190000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 watchdog expired at edge %0d: actual 0 expected 1", edgeK);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule